// File: doc/BRIEF.md
# MSI Page Table Entry Decoder

This block sits behind the walker that fetches one 16-byte entry of a flat MSI redirection table. It receives that entry as two 64-bit words (a low word and a high word), together with the guest address of the device write that caused the lookup, and it decides what to do with that write.

There are five possible outcomes:

- an invalid-entry fault;
- a configuration fault, raised for a reserved mode, a reserved bit that is set, or interrupt-file mode while the strap disables it;
- a hand-off to implementation-specific logic;
- an address substitution, in which the write passes straight to a physical interrupt page;
- a hand-off to the memory-resident interrupt-file updater.

For the address substitution, the block builds the physical address. For the hand-off to the interrupt-file updater, it delivers the file's base address, the page number of the notice target and the notice identity.

Classification and field extraction take one registered stage. The results appear with a one-cycle valid pulse in the cycle after the entry is presented. The results hold until the next entry arrives.

Top module: `msiPteDecoder`

## Requirements
- R1: `outValid` is high for exactly the one cycle after each cycle with `entryValid` high. All other outputs change only on the edge that captures an entry, and hold otherwise. After reset, every output is zero.
- R2: Action codes are 0 for an invalid-entry fault, 1 for a configuration fault, 2 for custom, 3 for translate and 4 for interrupt file. When low-word bit 0 is zero, the action is 0, whatever every other bit of both words and the strap hold.
- R3: When low-word bit 0 is one and low-word bit 63 is one, the action is 2, whatever the mode, the reserved bits, the high word and the strap hold.
- R4: With bit 0 set and bit 63 clear, the mode is low-word bits 2:1. Mode 3 selects translate and mode 1 selects interrupt file. Modes 0 and 2 give action 1.
- R5: In translate mode, `physAddr` is low-word bits 53:10 placed above access-address bits 11:0, zero-extended or truncated to `PA_W`. The high word has no effect.
- R6: In translate mode, a one in low-word bits 62:54 or 9:3 gives action 1.
- R7: In interrupt-file mode, `ifAddr` carries low-word bits 53:7 as address bits 55:9, with bits 8:0 zero, resized to `PA_W`.
- R8: In interrupt-file mode, `noticePpn` is high-word bits 53:10. `noticeId` is high-word bit 60 as bit 10, joined with high-word bits 9:0.
- R9: In interrupt-file mode, a one in low-word bits 62:54 or 6:3, or in high-word bits 63:61 or 59:54, gives action 1.
- R10: In interrupt-file mode, when `ifModeEn` is low, the action is 1.
- R11: `physAddr` is zero unless the captured action is 3. `ifAddr`, `noticePpn` and `noticeId` are zero unless the captured action is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryValid | input | 1 | Entry and access address are presented this cycle |
| entryLo | input | 64 | Low word of the table entry |
| entryHi | input | 64 | High word of the table entry |
| accessAddr | input | ADDR_W | Guest address of the device write |
| ifModeEn | input | 1 | Strap: interrupt-file mode is supported |
| outValid | output | 1 | One-cycle pulse marking new results |
| action | output | 3 | Decoded action code |
| physAddr | output | PA_W | Translated physical address |
| ifAddr | output | PA_W | Interrupt-file base address |
| noticePpn | output | 44 | Notice target page number |
| noticeId | output | 11 | Notice identity |

## Verification
Several classifications can be met by a single entry. The stimulus therefore places them together, to check which one decides:

- a cleared valid bit alongside a set custom flag, a set reserved bit and a reserved mode;
- a custom flag on an entry whose mode is reserved and whose reserved bits are set;
- a legal interrupt-file entry presented while the strap disables that mode.

In each case the action code must name the higher-priority outcome, and every address field must read zero. Consecutive entries on adjacent cycles are also applied, to show that each result appears exactly one cycle later without leaking fields from its neighbour.

// File: rtl/msiPteDecPkg.sv
package msiPteDecPkg;

  typedef enum logic [2:0] {
    ACT_FAULT_INVALID = 3'd0,
    ACT_FAULT_CONFIG  = 3'd1,
    ACT_CUSTOM        = 3'd2,
    ACT_TRANSLATE     = 3'd3,
    ACT_IFILE         = 3'd4
  } action_e;

  typedef enum logic [1:0] {
    MODE_RSVD0  = 2'd0,
    MODE_IFILE  = 2'd1,
    MODE_RSVD2  = 2'd2,
    MODE_XLATE  = 2'd3
  } mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic takeXlat;
    logic takeIfile;
  } strobe_t;

  localparam int unsigned RAW_ADDR_W = 56;
  localparam int unsigned NPPN_W     = 44;
  localparam int unsigned NID_W      = 11;

  // Bits that must be zero in each mode.
  localparam logic [63:0] XLAT_LO_RSVD  = 64'h7FC0_0000_0000_03F8;
  localparam logic [63:0] IFILE_LO_RSVD = 64'h7FC0_0000_0000_0078;
  localparam logic [63:0] IFILE_HI_RSVD = 64'hEFC0_0000_0000_0000;

endpackage

// File: rtl/msiPteCtrl.sv
module msiPteCtrl
  import msiPteDecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        entryValid,
  input  logic [63:0] entryLo,
  input  logic [63:0] entryHi,
  input  logic        ifModeEn,
  output strobe_t     strobes,
  output logic        outValid,
  output action_e     action
);

  action_e cls;
  mode_e   mode;
  logic    xlatRsvdHit;
  logic    ifRsvdHit;

  assign mode        = mode_e'(entryLo[2:1]);
  assign xlatRsvdHit = |(entryLo & XLAT_LO_RSVD);
  assign ifRsvdHit   = (|(entryLo & IFILE_LO_RSVD)) | (|(entryHi & IFILE_HI_RSVD));

  // Priority: valid, then custom, then mode and reserved checks.
  always_comb begin
    cls = ACT_FAULT_CONFIG;
    if (!entryLo[0]) begin
      cls = ACT_FAULT_INVALID;
    end else if (entryLo[63]) begin
      cls = ACT_CUSTOM;
    end else begin
      unique case (mode)
        MODE_XLATE: cls = xlatRsvdHit ? ACT_FAULT_CONFIG : ACT_TRANSLATE;
        MODE_IFILE: cls = (ifModeEn && !ifRsvdHit) ? ACT_IFILE : ACT_FAULT_CONFIG;
        default:    cls = ACT_FAULT_CONFIG;
      endcase
    end
  end

  always_comb begin
    strobes.capture   = entryValid;
    strobes.takeXlat  = (cls == ACT_TRANSLATE);
    strobes.takeIfile = (cls == ACT_IFILE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      action   <= ACT_FAULT_INVALID;
    end else begin
      outValid <= entryValid;
      if (entryValid) begin
        action <= cls;
      end
    end
  end

endmodule

// File: rtl/msiPteData.sv
module msiPteData
  import msiPteDecPkg::*;
#(
  parameter int unsigned PA_W   = 56,
  parameter int unsigned ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [63:0]         entryLo,
  input  logic [63:0]         entryHi,
  input  logic [ADDR_W-1:0]   accessAddr,
  output logic [PA_W-1:0]     physAddr,
  output logic [PA_W-1:0]     ifAddr,
  output logic [NPPN_W-1:0]   noticePpn,
  output logic [NID_W-1:0]    noticeId
);

  localparam int unsigned WIDE_W = (PA_W > RAW_ADDR_W) ? PA_W : RAW_ADDR_W;

  logic [RAW_ADDR_W-1:0] xlatRaw;
  logic [RAW_ADDR_W-1:0] ifRaw;
  logic [WIDE_W-1:0]     xlatWide;
  logic [WIDE_W-1:0]     ifWide;
  logic [PA_W-1:0]       xlatFit;
  logic [PA_W-1:0]       ifFit;
  logic [NPPN_W-1:0]     nPpnNext;
  logic [NID_W-1:0]      nIdNext;

  assign xlatRaw  = {entryLo[53:10], accessAddr[11:0]};
  assign ifRaw    = {entryLo[53:7], 9'd0};
  assign nPpnNext = entryHi[53:10];
  assign nIdNext  = {entryHi[60], entryHi[9:0]};

  // Zero-extend or clip to the physical width.
  always_comb begin
    xlatWide = '0;
    ifWide   = '0;
    xlatWide[RAW_ADDR_W-1:0] = xlatRaw;
    ifWide[RAW_ADDR_W-1:0]   = ifRaw;
    xlatFit = xlatWide[PA_W-1:0];
    ifFit   = ifWide[PA_W-1:0];
  end

  logic unusedBits;
  assign unusedBits = ^{accessAddr, entryLo, entryHi, xlatWide, ifWide};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr  <= '0;
      ifAddr    <= '0;
      noticePpn <= '0;
      noticeId  <= '0;
    end else if (strobes.capture) begin
      physAddr  <= strobes.takeXlat  ? xlatFit  : '0;
      ifAddr    <= strobes.takeIfile ? ifFit    : '0;
      noticePpn <= strobes.takeIfile ? nPpnNext : '0;
      noticeId  <= strobes.takeIfile ? nIdNext  : '0;
    end
  end

endmodule

// File: rtl/msiPteDecoder.sv
module msiPteDecoder
  import msiPteDecPkg::*;
#(
  parameter int unsigned PA_W   = 56,
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryValid,
  input  logic [63:0]       entryLo,
  input  logic [63:0]       entryHi,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic              ifModeEn,
  output logic              outValid,
  output logic [2:0]        action,
  output logic [PA_W-1:0]   physAddr,
  output logic [PA_W-1:0]   ifAddr,
  output logic [43:0]       noticePpn,
  output logic [10:0]       noticeId
);

  strobe_t strobes;
  action_e actionQ;

  msiPteCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .entryValid (entryValid),
    .entryLo    (entryLo),
    .entryHi    (entryHi),
    .ifModeEn   (ifModeEn),
    .strobes    (strobes),
    .outValid   (outValid),
    .action     (actionQ)
  );

  msiPteData #(.PA_W(PA_W), .ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .entryLo    (entryLo),
    .entryHi    (entryHi),
    .accessAddr (accessAddr),
    .physAddr   (physAddr),
    .ifAddr     (ifAddr),
    .noticePpn  (noticePpn),
    .noticeId   (noticeId)
  );

  assign action = actionQ;

  // R11: translated address only accompanies a translate result
  p_phys_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (actionQ != ACT_TRANSLATE) |-> (physAddr == '0));

  // R11: interrupt-file fields only accompany an interrupt-file result
  p_ifile_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (actionQ != ACT_IFILE) |-> (ifAddr == '0 && noticePpn == '0 && noticeId == '0));

  // R5: page offset passes through unchanged
  p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && actionQ == ACT_TRANSLATE) |-> (physAddr[11:0] == $past(accessAddr[11:0])));

  // R7: interrupt-file base is 512-byte aligned
  p_if_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    ifAddr[8:0] == 9'd0);

  // R2: cleared valid bit always yields the invalid fault
  p_invalid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(entryLo[0])) |-> (actionQ == ACT_FAULT_INVALID));

  // R3: custom flag on a valid entry always wins
  p_custom_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(entryLo[0] && entryLo[63])) |-> (actionQ == ACT_CUSTOM));

  // R10: interrupt-file result requires the strap
  p_strap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && actionQ == ACT_IFILE) |-> $past(ifModeEn));

endmodule

// File: tb/msiPteDecoder_test.sv
module msiPteDecoder_test;

  typedef struct packed {
    logic [63:0] lo;
    logic [63:0] hi;
    logic [63:0] addr;
    logic        en;
    logic [2:0]  act;
    logic [55:0] phys;
    logic [55:0] ifa;
    logic [43:0] nppn;
    logic [10:0] nid;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R5 translate, high word garbage ignored
    '{64'h0004_8D15_9E26_AC07, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_0ABC, 1'b1, 3'd3, 56'h12_3456_789A_BABC, 56'h0, 44'h0, 11'h0},
    // R5 translate, all-ones page number
    '{64'h003F_FFFF_FFFF_FC07, 64'h0, 64'h0000_0000_0000_0000, 1'b0, 3'd3, 56'hFF_FFFF_FFFF_F000, 56'h0, 44'h0, 11'h0},
    // R6 translate, reserved bit 5
    '{64'h0004_8D15_9E26_AC27, 64'h0, 64'h0000_0000_0000_0123, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R6 translate, reserved bit 54
    '{64'h0040_0000_0000_0007, 64'h0, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R6 translate, reserved bit 7
    '{64'h0000_0000_0000_0087, 64'h0, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R2 invalid with every other bit set
    '{64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd0, 56'h0, 56'h0, 44'h0, 11'h0},
    // R2 invalid all zero
    '{64'h0, 64'h0, 64'h0, 1'b0, 3'd0, 56'h0, 56'h0, 44'h0, 11'h0},
    // R3 custom minimal
    '{64'h8000_0000_0000_0001, 64'h0, 64'h0, 1'b0, 3'd2, 56'h0, 56'h0, 44'h0, 11'h0},
    // R3 custom with reserved mode and reserved bits
    '{64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 3'd2, 56'h0, 56'h0, 44'h0, 11'h0},
    // R4 mode 0
    '{64'h0000_0000_0000_0001, 64'h0, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R4 mode 2
    '{64'h0000_0000_0000_0005, 64'h0, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R7 R8 interrupt file full
    '{64'h0028_6CB0_F539_7D83, 64'h1003_FB72_EA61_D9A5, 64'hFFFF_0000_1234_5678, 1'b1, 3'd4, 56'h0, 56'hA1_B2C3_D4E5_F600, 44'h0FE_DCBA_9876, 11'h5A5},
    // R10 interrupt file with strap off
    '{64'h0028_6CB0_F539_7D83, 64'h1003_FB72_EA61_D9A5, 64'h0, 1'b0, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R9 high-word reserved bit 63
    '{64'h0028_6CB0_F539_7D83, 64'h9003_FB72_EA61_D9A5, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R9 high-word reserved bit 54
    '{64'h0000_0000_0000_0003, 64'h0040_0000_0000_0000, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R9 low-word reserved bit 4
    '{64'h0028_6CB0_F539_7D93, 64'h1003_FB72_EA61_D9A5, 64'h0, 1'b1, 3'd1, 56'h0, 56'h0, 44'h0, 11'h0},
    // R8 identity without bit 10, zero page
    '{64'h0000_0000_0000_0003, 64'h0000_0000_0000_03FF, 64'h0, 1'b1, 3'd4, 56'h0, 56'h0, 44'h0, 11'h3FF},
    // R7 lowest address bit of interrupt-file field
    '{64'h0000_0000_0000_0083, 64'h0, 64'h0, 1'b1, 3'd4, 56'h0, 56'h200, 44'h0, 11'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryValid = 1'b0;
  logic [63:0] entryLo = '0;
  logic [63:0] entryHi = '0;
  logic [63:0] accessAddr = '0;
  logic        ifModeEn = 1'b0;
  logic        outValid;
  logic [2:0]  action;
  logic [55:0] physAddr;
  logic [55:0] ifAddr;
  logic [43:0] noticePpn;
  logic [10:0] noticeId;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msiPteDecoder uut (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryLo(entryLo),
    .entryHi(entryHi), .accessAddr(accessAddr), .ifModeEn(ifModeEn),
    .outValid(outValid), .action(action), .physAddr(physAddr), .ifAddr(ifAddr),
    .noticePpn(noticePpn), .noticeId(noticeId)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    entryLo = v.lo; entryHi = v.hi; accessAddr = v.addr; ifModeEn = v.en;
  endtask

  task automatic checkOut(input string req, input vec_t v);
    chk({req, " outValid"}, 64'(outValid), 64'd1);
    chk({req, " action"}, 64'(action), 64'(v.act));
    chk({req, " physAddr"}, 64'(physAddr), 64'(v.phys));
    chk({req, " ifAddr"}, 64'(ifAddr), 64'(v.ifa));
    chk({req, " noticePpn"}, 64'(noticePpn), 64'(v.nppn));
    chk({req, " noticeId"}, 64'(noticeId), 64'(v.nid));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outValid", 64'(outValid), 64'd0);
    chk("R1 reset action", 64'(action), 64'd0);
    chk("R1 reset physAddr", 64'(physAddr), 64'd0);
    chk("R1 reset ifAddr", 64'(ifAddr), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk, one entry at a time
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      entryValid = 1'b1;
      @(negedge clk);
      entryValid = 1'b0;
      checkOut($sformatf("vec%0d", i), VECS[i]);
      @(negedge clk);
      chk("R1 pulse ends", 64'(outValid), 64'd0);
    end

    // R1 hold: inputs change without entryValid, outputs stay
    drive(VECS[11]);
    entryValid = 1'b1;
    @(negedge clk);
    entryValid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R1 hold outValid", 64'(outValid), 64'd0);
    chk("R1 hold action", 64'(action), 64'd4);
    chk("R1 hold ifAddr", 64'(ifAddr), 64'(VECS[11].ifa));
    chk("R1 hold noticeId", 64'(noticeId), 64'(VECS[11].nid));
    chk("R1 hold physAddr", 64'(physAddr), 64'd0);

    // R1 R11 back-to-back: translate then interrupt file then invalid
    drive(VECS[0]);
    entryValid = 1'b1;
    @(negedge clk);
    checkOut("R11 b2b first", VECS[0]);
    drive(VECS[11]);
    @(negedge clk);
    checkOut("R11 b2b second", VECS[11]);
    drive(VECS[5]);
    @(negedge clk);
    entryValid = 1'b0;
    checkOut("R2 b2b third", VECS[5]);
    @(negedge clk);
    chk("R1 b2b pulse ends", 64'(outValid), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule